// File: doc/BRIEF.md
# I2C Controller FIFO Status and Interrupt Unit

This block sits between a register bus and the byte engine of an I2C controller. It holds the bytes queued for transmission and the bytes received from the wire, each in a 16-entry FIFO. It reports how full each FIFO is and exposes status flags. It also collects interrupt sources into a sticky status register that software clears by writing ones. The sources are passed through per-source enables and a global enable to drive one interrupt line.

Software talks to the block through a word-indexed register port. Writing the transmit-data register pushes one 10-bit entry: 8 data bits plus 2 control bits for the bus engine. Reading the receive-data register pops one byte. The byte engine drains the transmit FIFO through a valid/ready stream: `tx_valid` stays high while an entry is available, and the entry is consumed on a cycle where `tx_ready` is also high. The engine fills the receive FIFO through a second valid/ready stream. There, `rx_ready` falls only while the FIFO holds 16 entries, and a byte offered in that state waits at the source. A soft reset is triggered by writing a fixed key to a dedicated register.

Register indices on `reg_addr`: 0 control (bit1 holds the transmit FIFO empty), 1 status, 2 transmit data, 3 receive data, 4 transmit occupancy, 5 receive occupancy, 6 receive threshold, 7 interrupt status, 8 interrupt enable, 9 global enable (bit31), 10 soft reset. Reads return data combinationally in the cycle `reg_rd` is high; writes take effect at the clock edge.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset both FIFOs are empty, the status register reads 0xC0 with `bus_busy` low, the occupancy, enable and global-enable registers read 0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: Entries written to register 2 (bits 9:0) appear on `tx_data` in write order. `tx_valid` is low when the transmit FIFO is empty. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.
- R3: A write to register 2 while the transmit FIFO holds 16 entries is dropped and changes neither its contents nor its occupancy.
- R4: `rx_ready` is low exactly when the receive FIFO holds 16 entries. Reads of register 3 return received bytes in arrival order in bits 7:0. A read while the FIFO is empty returns 0 and leaves the occupancy at 0.
- R5: Registers 4 and 5 read, in bits 3:0, the entry count minus one, and read 0 when the FIFO is empty.
- R6: Status register bits: bit2 mirrors `bus_busy`, bit4 is transmit full, bit5 is receive full, bit6 is receive empty, bit7 is transmit empty. All other bits read 0.
- R7: Register 6 holds a zero-based threshold T in bits 3:0, with a reset value of 0. Interrupt status bit3 is set while the receive count is at least T+1.
- R8: Interrupt status bits are sticky. Bit0 is set by an `arb_lost` pulse and bit1 by an `xfer_err` pulse. Bit2 is set while the transmit FIFO is empty, bit4 while `bus_busy` is low, and bit7 while the transmit count is at most 8. Writing 1 to a bit of register 7 clears it, and writing 0 leaves it unchanged. When a source event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly when register 9 bit31 is set and the interrupt status ANDed with the interrupt-enable register (bits 7:0) is nonzero.
- R10: Writing 0xA to register 10 returns all registers, status bits and both FIFOs to their reset state. Any other value written there has no effect.
- R11: While control bit1 is 1, the transmit FIFO is emptied, `tx_valid` is low and writes to register 2 are dropped. Normal operation resumes once bit1 is written back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on register 3) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Byte engine takes the transmit entry |
| tx_data | output | 10 | Transmit entry (control bits 9:8, data 7:0) |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive FIFO can accept a byte |
| rx_data | input | 8 | Received byte |
| bus_busy | input | 1 | Bus currently occupied |
| arb_lost | input | 1 | Arbitration-lost pulse |
| xfer_err | input | 1 | Transfer error pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a source event setting an interrupt status bit, and a software write of 1 clearing that bit. The bench provokes this by raising `arb_lost` in exactly the cycle that writes 1 to bit0 of register 7. It passes only if a later read still shows the bit set. The level-driven sources run into the same collision on every clearing write, because their condition persists. The threshold sweep and the half-empty sweep check that a cleared bit comes back exactly when its condition holds.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_STAT  = 4'd1;
  localparam logic [3:0] A_TXD   = 4'd2;
  localparam logic [3:0] A_RXD   = 4'd3;
  localparam logic [3:0] A_TXOCC = 4'd4;
  localparam logic [3:0] A_RXOCC = 4'd5;
  localparam logic [3:0] A_RXTHR = 4'd6;
  localparam logic [3:0] A_ISR   = 4'd7;
  localparam logic [3:0] A_IER   = 4'd8;
  localparam logic [3:0] A_GIE   = 4'd9;
  localparam logic [3:0] A_SRST  = 4'd10;
  localparam logic [31:0] SRST_KEY = 32'hA;
  localparam int IRQ_N = 8;
  // interrupt source bit positions
  localparam int IB_ARB  = 0;
  localparam int IB_ERR  = 1;
  localparam int IB_TXE  = 2;
  localparam int IB_RXT  = 3;
  localparam int IB_IDLE = 4;
  localparam int IB_TXH  = 7;
endpackage

// File: rtl/fiu_fifo.sv
module fiu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fiu_irq.sv
module fiu_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] w1c_vec,
  output logic [N-1:0] isr
);
  // per bit: a set in the same cycle as a clearing write wins
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clr)   isr[i] <= 1'b0;
      else if (set_vec[i]) isr[i] <= 1'b1;
      else if (w1c_vec[i]) isr[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fiu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TXW   = 10,
  parameter int RXW   = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int OW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [TXW-1:0] tx_data,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [RXW-1:0] rx_data,
  input  logic           bus_busy,
  input  logic           arb_lost,
  input  logic           xfer_err,
  output logic           irq
);
  logic srst, hold_q, gie_q;
  logic [OW-1:0] thr_q;
  logic [IRQ_N-1:0] ier_q, isr_q, set_vec, w1c_vec;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [RXW-1:0] rx_head;

  assign srst = reg_wr && (reg_addr == A_SRST) && (reg_wdata == SRST_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      hold_q <= 1'b0;
      thr_q  <= '0;
      ier_q  <= '0;
      gie_q  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  hold_q <= reg_wdata[1];
        A_RXTHR: thr_q  <= reg_wdata[OW-1:0];
        A_IER:   ier_q  <= reg_wdata[IRQ_N-1:0];
        A_GIE:   gie_q  <= reg_wdata[31];
        default: ;
      endcase
    end
  end

  fiu_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txf (
    .clk, .rst_n,
    .clr       (srst || hold_q),
    .push      (reg_wr && (reg_addr == A_TXD) && !hold_q),
    .push_data (reg_wdata[TXW-1:0]),
    .pop       (tx_ready && !hold_q),
    .head      (tx_data),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  assign tx_valid = !tx_empty && !hold_q;
  assign rx_ready = !rx_full;

  fiu_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxf (
    .clk, .rst_n,
    .clr       (srst),
    .push      (rx_valid && rx_ready),
    .push_data (rx_data),
    .pop       (reg_rd && (reg_addr == A_RXD)),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IB_ARB]  = arb_lost;
    set_vec[IB_ERR]  = xfer_err;
    set_vec[IB_TXE]  = tx_empty;
    set_vec[IB_RXT]  = rx_cnt > {1'b0, thr_q};
    set_vec[IB_IDLE] = !bus_busy;
    set_vec[IB_TXH]  = tx_cnt <= CW'(DEPTH / 2);
    w1c_vec = (reg_wr && reg_addr == A_ISR) ? reg_wdata[IRQ_N-1:0] : '0;
  end

  fiu_irq #(.N(IRQ_N)) u_irq (
    .clk, .rst_n,
    .clr     (srst),
    .set_vec (set_vec),
    .w1c_vec (w1c_vec),
    .isr     (isr_q)
  );

  assign irq = gie_q && |(isr_q & ier_q);

  function automatic logic [OW-1:0] occ(input logic [CW-1:0] c);
    return (c == '0) ? '0 : OW'(c - 1'b1);
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[1] = hold_q;
      A_STAT:  reg_rdata[7:0] = {tx_empty, rx_empty, rx_full, tx_full, 1'b0, bus_busy, 2'b00};
      A_RXD:   reg_rdata[RXW-1:0] = rx_head;
      A_TXOCC: reg_rdata[OW-1:0] = occ(tx_cnt);
      A_RXOCC: reg_rdata[OW-1:0] = occ(rx_cnt);
      A_RXTHR: reg_rdata[OW-1:0] = thr_q;
      A_ISR:   reg_rdata[IRQ_N-1:0] = isr_q;
      A_IER:   reg_rdata[IRQ_N-1:0] = ier_q;
      A_GIE:   reg_rdata[31] = gie_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/fifo_irq_unit_chk.sv
module fifo_irq_unit_chk
  import fiu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [9:0]    tx_data,
  input logic          rx_ready,
  input logic          arb_lost,
  input logic          xfer_err,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    isr_q,
  input logic [7:0]    ier_q,
  input logic          irq
);
  logic key_wr, hold_wr, clr1_wr;
  assign key_wr  = reg_wr && reg_addr == A_SRST && reg_wdata == SRST_KEY;
  assign hold_wr = reg_wr && reg_addr == A_CTRL && reg_wdata[1];
  assign clr1_wr = reg_wr && reg_addr == A_ISR && reg_wdata[IB_ERR];

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !key_wr && !hold_wr |=> tx_valid && $stable(tx_data));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  p_rx_backpr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> rx_cnt == CW'(DEPTH));

  p_arb_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost && !key_wr |=> isr_q[IB_ARB]);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err && !key_wr |=> isr_q[IB_ERR]);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[IB_ERR] && !key_wr && !clr1_wr |=> isr_q[IB_ERR]);

  p_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> tx_cnt == '0 && rx_cnt == '0 && ier_q == '0 && !irq);
endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_fifo_irq_unit.sv
module sim_fifo_irq_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_ready = 0;
  logic [9:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic bus_busy = 0, arb_lost = 0, xfer_err = 0, irq;
  int n_chk = 0, n_fail = 0;
  logic done = 0;

  always #5 clk = ~clk;

  fifo_irq_unit u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
    @(negedge clk);
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic rx_push(input logic [7:0] d, output logic rdy);
    rx_valid = 1; rx_data = d;
    #1 rdy = rx_ready;
    @(negedge clk); rx_valid = 0;
    @(negedge clk);
  endtask

  task automatic tx_pop(output logic v, output logic [9:0] d);
    tx_ready = 1;
    #1 v = tx_valid; d = tx_data;
    @(negedge clk); tx_ready = 0;
    @(negedge clk);
  endtask

  function automatic logic [9:0] tpat(input int k);
    return 10'((k * 37 + 5) % 1024);
  endfunction
  function automatic logic [7:0] rpat(input int k);
    return 8'((k * 11 + 3) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v, rdy;
    logic [9:0] td;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 1);
    @(negedge clk);
    rdchk("R1 status", 4'd1, 32'hC0);
    rdchk("R1 txocc", 4'd4, 0);
    rdchk("R1 rxocc", 4'd5, 0);
    rdchk("R1 ier", 4'd8, 0);
    rdchk("R1 gie", 4'd9, 0);
    rdchk("R8 level sources", 4'd7, 32'h94);

    // transmit fill sweep
    for (int k = 0; k < 16; k++) begin
      wr(4'd2, {22'd0, tpat(k)});
      rdchk("R5 txocc", 4'd4, k);
      rd(4'd1, d);
      check("R6 tx full bit4", d[4], k == 15);
      check("R6 tx empty bit7", d[7], 0);
      wr(4'd7, 32'h80);
      rd(4'd7, d);
      check("R8 tx half bit7", d[7], (k + 1) <= 8);
    end
    wr(4'd2, 32'h3FF);
    rdchk("R3 overflow dropped", 4'd4, 15);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 hold while not ready", tx_data, tpat(0));
    end
    for (int k = 0; k < 16; k++) begin
      tx_pop(v, td);
      check("R2 tx valid", v, 1);
      check("R2 tx order", td, tpat(k));
      rdchk("R5 txocc drain", 4'd4, (k == 15) ? 0 : 14 - k);
    end
    tx_pop(v, td);
    check("R2 empty no valid", v, 0);

    // transmit hold
    for (int k = 0; k < 3; k++) wr(4'd2, {22'd0, tpat(k + 20)});
    wr(4'd0, 32'h2);
    check("R11 tx_valid low", tx_valid, 0);
    rd(4'd1, d);
    check("R11 tx empty", d[7], 1);
    wr(4'd2, 32'h55);
    rd(4'd1, d);
    check("R11 push dropped", d[7], 1);
    wr(4'd0, 32'h0);
    rdchk("R6 status idle", 4'd1, 32'hC0);
    wr(4'd2, {22'd0, tpat(9)});
    tx_pop(v, td);
    check("R11 resume", {v, td}, {1'b1, tpat(9)});

    // receive fill sweep
    for (int k = 0; k < 16; k++) begin
      rx_push(rpat(k), rdy);
      check("R4 rx_ready", rdy, 1);
      rdchk("R5 rxocc", 4'd5, k);
      rd(4'd1, d);
      check("R6 rx full bit5", d[5], k == 15);
      check("R6 rx empty bit6", d[6], 0);
    end
    rx_push(8'hEE, rdy);
    check("R4 backpressure", rdy, 0);
    rdchk("R4 rxocc full", 4'd5, 15);
    for (int k = 0; k < 16; k++) rdchk("R4 rx order", 4'd3, rpat(k));
    rdchk("R4 empty read zero", 4'd3, 0);
    rdchk("R4 rxocc empty", 4'd5, 0);
    rd(4'd1, d);
    check("R6 rx empty", d[6], 1);

    // threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(4'd10, 32'hA);
      wr(4'd6, t);
      rdchk("R7 thr readback", 4'd6, t);
      for (int c = 1; c <= 16; c++) begin
        rx_push(8'(c), rdy);
        rd(4'd7, d);
        check("R7 threshold bit3", d[3], c >= t + 1);
      end
    end

    // sticky / write-one-to-clear
    wr(4'd10, 32'hA);
    arb_lost = 1; @(negedge clk); arb_lost = 0; @(negedge clk);
    rd(4'd7, d); check("R8 arb set", d[0], 1);
    wr(4'd7, 32'h0);
    rd(4'd7, d); check("R8 write0 keeps", d[0], 1);
    wr(4'd7, 32'h1);
    rd(4'd7, d); check("R8 write1 clears", d[0], 0);
    xfer_err = 1; @(negedge clk); xfer_err = 0; @(negedge clk);
    rd(4'd7, d); check("R8 err set", d[1], 1);
    wr(4'd7, 32'h2);
    rd(4'd7, d); check("R8 err clear", d[1], 0);
    arb_lost = 1; reg_wr = 1; reg_addr = 4'd7; reg_wdata = 32'h1;
    @(negedge clk); arb_lost = 0; reg_wr = 0; @(negedge clk);
    rd(4'd7, d); check("R8 set wins over clear", d[0], 1);
    bus_busy = 1;
    wr(4'd7, 32'h10);
    rd(4'd7, d); check("R8 idle cleared while busy", d[4], 0);
    rd(4'd1, d); check("R6 busy bit2", d[2], 1);
    bus_busy = 0; @(negedge clk);
    rd(4'd7, d); check("R8 idle set", d[4], 1);

    // irq gating, bit0 pending, bit1 clear
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 2; e++) begin
        wr(4'd8, e);
        wr(4'd9, g << 31);
        check("R9 irq gate", irq, (g == 1) && (e == 1));
      end
    wr(4'd8, 32'h2);
    check("R9 disabled source", irq, 0);
    wr(4'd8, 32'h1);
    check("R9 enabled again", irq, 1);
    wr(4'd7, 32'h1);
    check("R9 cleared source", irq, 0);

    // soft reset key
    wr(4'd2, 32'h12);
    wr(4'd8, 32'h5);
    wr(4'd10, 32'h5);
    rdchk("R10 wrong key ignored", 4'd8, 32'h5);
    wr(4'd10, 32'hA);
    rdchk("R10 ier reset", 4'd8, 0);
    rdchk("R10 gie reset", 4'd9, 0);
    rdchk("R10 fifos empty", 4'd1, 32'hC0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule